// File: doc/BRIEF.md
# Multiline Receive Silo with Timed Interrupt

This block is the shared receive buffer of a sixteen-line serial multiplexer. Every line receiver, the modem-status monitor and the diagnostic logic push into one first-in first-out store. Each entry is tagged with its source line, and a single read port hands the entries back one per read strobe. Data characters carry their parity, framing and overrun error flags. Modem-change reports and diagnostic codes are stored in the same queue and are marked as non-data.

The receive interrupt does not follow a plain fill threshold. A timeout code picks the mode. In timed mode, the request is raised a programmed number of millisecond ticks after the store stops being empty. In immediate mode, it is raised on every stored entry. In poll mode, only modem changes and the three-quarter alarm level raise it. When reset is released, a built-in self-test loads eight diagnostic entries. Software drains these before normal use.

Top module: `rx_silo`

## Requirements
- R1: The read word is `{valid, status[2:0], line[3:0], byte[7:0]}` with valid in bit 15. It shows the oldest entry while the store holds any. It reads as all zeros when the store is empty.
- R2: A data entry has status `{overrun, framing, parity}` in bits 14:12, the source line in bits 11:8 and the character in bits 7:0. Entries come out in the order they were stored, one per cycle in which `rd_en` is high.
- R3: A non-data entry has bits 14:12 = 3'b111. A modem-change entry has bit 7 = 0, the reporting line in bits 11:8 and the carrier state in bit 0. A diagnostic entry has bit 7 = 1, the code in bits 6:0 and line field 0.
- R4: After reset is released, the store holds exactly eight diagnostic entries with codes 0 to 7, in ascending order.
- R5: At most one entry is stored per cycle. The priority is self-test, then the diagnostic port, then the modem port, then the lowest-numbered striking line. Every source that loses arms the pending-overrun condition.
- R6: When the store holds 256 entries, a new entry is dropped unless a read happens in the same cycle. A drop arms the pending-overrun condition. The next stored data entry carries the overrun flag in bit 14, which clears the condition. If that data entry already has both its parity and framing flags set, the overrun flag is not set on it and the condition carries on to the following data entry.
- R7: With a timeout code of 2 to 255, the request is raised on the code-th `ms_tick` counted after the entry that made the store non-empty. Entries arriving later do not restart the count.
- R8: With timeout code 0, no timer runs. The request is raised only when a modem-change entry is stored or the fill level reaches 192 entries. These two events also raise the request in every other mode.
- R9: With timeout code 1, the request is raised at the clock edge that stores any entry.
- R10: Reading the store until it is empty clears the request.
- R11: `irq` is the request ANDed with `rx_ie`. While `rx_ie` is low the request is kept, and it appears at once when `rx_ie` rises.
- R12: A read strobe while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_stb | input | 16 | Per-line character-received strobes |
| rx_data | input | 128 | Received characters, line i in bits 8i+7:8i |
| rx_perr | input | 16 | Per-line parity-error flags |
| rx_ferr | input | 16 | Per-line framing-error flags |
| mdm_stb | input | 1 | Modem-change report strobe |
| mdm_line | input | 4 | Line of the modem-change report |
| mdm_dcd | input | 1 | Carrier state of the modem-change report |
| diag_stb | input | 1 | Diagnostic push strobe |
| diag_code | input | 7 | Diagnostic code |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| tmo_code | input | 8 | Timeout code: 0 poll, 1 immediate, 2..255 milliseconds |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_en | input | 1 | Read strobe; removes the oldest entry |
| rd_word | output | 16 | Oldest entry with valid flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The hardest situations to reach are at the full store and the overrun flag that follows a loss. The flag that follows a loss must land on the next data entry and not on a status entry. It must also skip a character that already carries both line errors. The bench fills the store to exactly 191, 192 and then 256 entries, drops one character and frees a slot. It also forces same-cycle collisions of all four source kinds. Random traffic then mixes single strikes, two-line collisions, modem and diagnostic pushes, and reads against a queue model that carries the pending-overrun state.

// File: rtl/rx_silo.sv
module rx_silo #(
  parameter int LINES = 16,
  parameter int DEPTH = 256,
  parameter int ALARM = 192,
  parameter int STN   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES-1:0]     rx_stb,
  input  logic [LINES*8-1:0]   rx_data,
  input  logic [LINES-1:0]     rx_perr,
  input  logic [LINES-1:0]     rx_ferr,
  input  logic                 mdm_stb,
  input  logic [$clog2(LINES)-1:0] mdm_line,
  input  logic                 mdm_dcd,
  input  logic                 diag_stb,
  input  logic [6:0]           diag_code,
  input  logic                 ms_tick,
  input  logic [7:0]           tmo_code,
  input  logic                 rx_ie,
  input  logic                 rd_en,
  output logic [12+$clog2(LINES)-1:0] rd_word,
  output logic                 irq
);
  localparam int LW = $clog2(LINES);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int WW = 12 + LW;
  localparam int SW = $clog2(STN) + 1;

  logic [WW-2:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_n;
  logic [SW-1:0] st_cnt;
  logic          ovr, pend, run;
  logic [7:0]    tmr;

  logic          st_act, req, lost, is_data, is_mdm, use_ovr, push_ok, pop, tmo_exp, pend_set;
  logic [LW-1:0] dl;
  logic          dpe, dfe;
  logic [WW-2:0] ent;

  assign st_act = (st_cnt < SW'(STN));
  assign req    = st_act | diag_stb | mdm_stb | (|rx_stb);
  assign lost   = $countones({st_act, diag_stb, mdm_stb, rx_stb}) > 1;
  assign pop    = rd_en && (cnt != '0);
  assign push_ok = req && ((cnt < CW'(DEPTH)) || pop);

  always_comb begin
    dl = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (rx_stb[i]) dl = LW'(i);
  end

  assign dpe     = rx_perr[dl];
  assign dfe     = rx_ferr[dl];
  assign use_ovr = ovr && !(dpe && dfe);

  always_comb begin
    is_data = 1'b0;
    is_mdm  = 1'b0;
    if (st_act)
      ent = {3'b111, {LW{1'b0}}, 1'b1, 7'(st_cnt)};
    else if (diag_stb)
      ent = {3'b111, {LW{1'b0}}, 1'b1, diag_code};
    else if (mdm_stb) begin
      ent    = {3'b111, mdm_line, 7'd0, mdm_dcd};
      is_mdm = 1'b1;
    end else begin
      ent     = {use_ovr, dfe, dpe, dl, rx_data[dl*8 +: 8]};
      is_data = |rx_stb;
    end
  end

  assign cnt_n = cnt + CW'(push_ok) - CW'(pop);

  assign tmo_exp  = run && ms_tick && (tmo_code >= 8'd2) &&
                    ({1'b0, tmr} + 9'd1 >= {1'b0, tmo_code});
  assign pend_set = (push_ok && is_mdm) || (cnt_n >= CW'(ALARM)) ||
                    (tmo_code == 8'd1 && push_ok) || tmo_exp;

  always_ff @(posedge clk)
    if (push_ok) mem[wp] <= ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      st_cnt <= '0;
      ovr    <= 1'b0;
      pend   <= 1'b0;
      run    <= 1'b0;
      tmr    <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop)     rp <= rp + 1'b1;
      cnt <= cnt_n;
      if (st_act) st_cnt <= st_cnt + 1'b1;
      ovr <= (ovr && !(push_ok && is_data && use_ovr)) || lost || (req && !push_ok);
      if (cnt_n == '0)   pend <= 1'b0;
      else if (pend_set) pend <= 1'b1;
      if (push_ok && cnt == '0) begin
        run <= 1'b1;
        tmr <= '0;
      end else if (cnt_n == '0) begin
        run <= 1'b0;
      end else if (run && ms_tick) begin
        tmr <= tmr + 1'b1;
        if (tmo_exp) run <= 1'b0;
      end
    end
  end

  assign rd_word = (cnt != '0) ? {1'b1, mem[rp]} : '0;
  assign irq     = pend && rx_ie;
endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
  parameter int WW = 16,
  parameter int CW = 9,
  parameter int DEPTH = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic [WW-1:0] rd_word,
  input logic          irq,
  input logic          rx_ie,
  input logic [7:0]    tmo_code,
  input logic          rd_en,
  input logic [CW-1:0] cnt,
  input logic          push_ok
);
  // R1
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word[WW-1] |-> rd_word == '0);
  // R10
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_word[WW-1]);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !irq);
  // R9
  immediate_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_code == 8'd1 && push_ok) |=> (irq || !rx_ie));
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !rd_en) |=> cnt == CW'(DEPTH));
  // R12
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !push_ok) |=> cnt == '0);
endmodule

bind rx_silo rx_silo_chk #(.WW(WW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .irq(irq), .rx_ie(rx_ie),
  .tmo_code(tmo_code), .rd_en(rd_en), .cnt(cnt), .push_ok(push_ok)
);

// File: tb/tb_rx_silo.sv
`timescale 1ns/1ps
module tb_rx_silo;
  logic clk = 0, rst_n = 0;
  logic [15:0] rx_stb = '0, rx_perr = '0, rx_ferr = '0;
  logic [127:0] rx_data = '0;
  logic mdm_stb = 0, mdm_dcd = 0, diag_stb = 0, ms_tick = 0, rx_ie = 0, rd_en = 0;
  logic [3:0] mdm_line = '0;
  logic [6:0] diag_code = '0;
  logic [7:0] tmo_code = '0;
  logic [15:0] rd_word;
  logic irq;

  int checks = 0, errors = 0;
  logic [15:0] q[$];
  bit ovr_m = 0;

  always #10 clk = ~clk;

  rx_silo dut (
    .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .mdm_stb(mdm_stb), .mdm_line(mdm_line), .mdm_dcd(mdm_dcd),
    .diag_stb(diag_stb), .diag_code(diag_code), .ms_tick(ms_tick), .tmo_code(tmo_code),
    .rx_ie(rx_ie), .rd_en(rd_en), .rd_word(rd_word), .irq(irq)
  );

  function automatic logic [15:0] head();
    return (q.size() > 0) ? q[0] : 16'h0000;
  endfunction

  function automatic logic [15:0] diag_w(input logic [6:0] c);
    return {1'b1, 3'b111, 4'h0, 1'b1, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    int n, l;
    logic [15:0] ent;
    bit isd, pe, fe, flag;
    if (rd_en) chk(rd_word === head(), tag, rd_word, head());
    n = $countones(rx_stb) + int'(mdm_stb) + int'(diag_stb);
    if (rd_en && q.size() > 0) void'(q.pop_front());
    if (n > 0) begin
      isd = 0; flag = 0;
      if (diag_stb) ent = diag_w(diag_code);
      else if (mdm_stb) ent = {1'b1, 3'b111, mdm_line, 7'd0, mdm_dcd};
      else begin
        l = 0;
        for (int i = 15; i >= 0; i--) if (rx_stb[i]) l = i;
        pe = rx_perr[l]; fe = rx_ferr[l];
        flag = ovr_m && !(pe && fe);
        ent = {1'b1, flag, fe, pe, 4'(l), rx_data[l*8 +: 8]};
        isd = 1;
      end
      if (q.size() < 256) begin
        q.push_back(ent);
        if (isd && flag) ovr_m = 0;
      end else ovr_m = 1;
      if (n > 1) ovr_m = 1;
    end
    @(negedge clk);
    rx_stb = '0; rx_perr = '0; rx_ferr = '0; mdm_stb = 0; diag_stb = 0; rd_en = 0; ms_tick = 0;
  endtask

  task automatic put(input int l, input logic [7:0] b, input bit pe, input bit fe);
    rx_stb[l] = 1'b1; rx_data[l*8 +: 8] = b; rx_perr[l] = pe; rx_ferr[l] = fe;
  endtask

  task automatic pop_one(input string tag);
    rd_en = 1; cycle(tag);
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) pop_one(tag);
    chk(rd_word === 16'h0, "R1 empty after drain", rd_word, 0);
    chk(irq === 1'b0, "R10 irq cleared by drain", irq, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rd_word === 16'h0 && irq === 1'b0, "R1 reset state", {rd_word, 15'd0, irq}, 0);
    rst_n = 1;
    repeat (12) @(negedge clk);
    // R4 self-test entries
    for (int i = 0; i < 8; i++) begin
      q.push_back(diag_w(7'(i)));
      chk(rd_word === diag_w(7'(i)), "R4 self-test code", rd_word, diag_w(7'(i)));
      pop_one("R4");
    end
    chk(rd_word === 16'h0, "R1 empty word", rd_word, 0);
    // R12
    rd_en = 1; cycle("R12");
    chk(rd_word === 16'h0, "R12 pop on empty", rd_word, 0);

    // R8 poll mode
    tmo_code = 0; rx_ie = 1;
    put(4, 8'hA5, 1, 0); cycle("R2");
    put(7, 8'h3C, 0, 1); cycle("R2");
    repeat (300) begin ms_tick = 1; cycle("R8"); end
    chk(irq === 1'b0, "R8 no irq on data in poll mode", irq, 0);
    chk(rd_word === 16'h94A5, "R2 data word with parity", rd_word, 16'h94A5);
    mdm_stb = 1; mdm_line = 4'd9; mdm_dcd = 1; cycle("R3");
    chk(irq === 1'b1, "R8 irq on modem change", irq, 1);
    pop_one("R2");
    chk(rd_word === 16'hA73C, "R2 data word with framing", rd_word, 16'hA73C);
    pop_one("R2");
    chk(rd_word === 16'hF901, "R3 modem word", rd_word, 16'hF901);
    drain("R3");

    // R9 immediate mode
    tmo_code = 1;
    put(0, 8'h11, 0, 0); cycle("R9");
    chk(irq === 1'b1, "R9 immediate irq", irq, 1);
    drain("R9");

    // R7 timed mode
    tmo_code = 5;
    put(2, 8'h22, 0, 0); cycle("R7");
    ms_tick = 1; cycle("R7");
    ms_tick = 1; cycle("R7");
    put(3, 8'h33, 0, 0); cycle("R7");
    ms_tick = 1; cycle("R7");
    ms_tick = 1; cycle("R7");
    chk(irq === 1'b0, "R7 before timeout", irq, 0);
    ms_tick = 1; cycle("R7");
    chk(irq === 1'b1, "R7 at timeout", irq, 1);
    drain("R7");

    // R11 gating
    tmo_code = 1; rx_ie = 0;
    put(5, 8'h55, 0, 0); cycle("R11");
    chk(irq === 1'b0, "R11 gated", irq, 0);
    rx_ie = 1; #1;
    chk(irq === 1'b1, "R11 kept request shows", irq, 1);
    drain("R11");

    // R5 priority
    tmo_code = 0;
    diag_stb = 1; diag_code = 7'h2A; mdm_stb = 1; mdm_line = 4'd1; put(3, 8'h03, 0, 0); put(9, 8'h09, 0, 0);
    cycle("R5");
    put(2, 8'h02, 0, 0); cycle("R5");
    put(9, 8'h99, 0, 0); put(3, 8'h33, 0, 0); cycle("R5");
    put(5, 8'h05, 0, 0); cycle("R5");
    chk(rd_word === diag_w(7'h2A), "R5 diagnostic wins", rd_word, diag_w(7'h2A));
    pop_one("R5");
    chk(rd_word === 16'hC202, "R5 loss marks next data", rd_word, 16'hC202);
    pop_one("R5");
    chk(rd_word === 16'h8333, "R5 lowest line wins", rd_word, 16'h8333);
    pop_one("R5");
    chk(rd_word === 16'hC505, "R5 two-line loss marks next", rd_word, 16'hC505);
    drain("R5");

    // R6 overrun skips a character carrying both errors
    put(1, 8'h01, 0, 0); put(6, 8'h06, 0, 0); cycle("R6");
    put(8, 8'h88, 1, 1); cycle("R6");
    put(8, 8'h89, 0, 0); cycle("R6");
    pop_one("R6");
    chk(rd_word === 16'hB888, "R6 both errors no overrun", rd_word, 16'hB888);
    pop_one("R6");
    chk(rd_word === 16'hC889, "R6 overrun carried", rd_word, 16'hC889);
    drain("R6");

    // R8 alarm and R6 full
    for (int i = 0; i < 191; i++) begin put(i % 16, 8'(i), 0, 0); cycle("R8"); end
    chk(irq === 1'b0, "R8 below alarm", irq, 0);
    put(0, 8'hF0, 0, 0); cycle("R8");
    chk(irq === 1'b1, "R8 alarm level", irq, 1);
    for (int i = 192; i < 256; i++) begin put(i % 16, 8'(i), 0, 0); cycle("R6"); end
    put(4, 8'hEE, 0, 0); cycle("R6");
    chk(q.size() == 256, "R6 model full", q.size(), 256);
    pop_one("R6");
    put(7, 8'h77, 0, 0); cycle("R6");
    for (int i = 0; i < 255; i++) pop_one("R6");
    chk(rd_word === 16'hC777, "R6 overrun after drop", rd_word, 16'hC777);
    drain("R6");

    // random traffic
    tmo_code = 0; rx_ie = 0;
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom % 10;
      if (r < 5) put($urandom % 16, 8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0);
      else if (r == 5) begin mdm_stb = 1; mdm_line = 4'($urandom); mdm_dcd = 1'($urandom); end
      else if (r == 6) begin diag_stb = 1; diag_code = 7'($urandom); end
      else if (r == 7) begin put($urandom % 8, 8'($urandom), 0, 0); put(8 + $urandom % 8, 8'($urandom), 0, 0); end
      rd_en = ($urandom % 100) < 45;
      cycle("R2 random");
    end
    chk(irq === 1'b0, "R11 random gated", irq, 0);
    drain("R2 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule